// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Master

This controller runs a three-wire serial EEPROM that holds 16-bit words at 8-bit addresses. The host starts one of four operations: read a word, write a word, allow programming, or lock programming. It does this with a single-cycle request that carries an operation code, an address and write data. The block drives chip select, the serial clock and the serial output, samples the serial input, and returns a done pulse together with read data. Each command frame is sent most significant bit first. A frame is a start bit of 1, a 2-bit opcode and the address, and a write frame also carries 16 data bits.

A host write is one command. The controller sends the programming-allow frame, then the write frame. It then raises chip select again and polls the serial input until the device reports ready. Last, it sends the programming-lock frame. A cycle counter bounds the ready poll. If the poll runs out, the error flag is set and the block goes idle. `CLK_DIV` sets the length of one clock phase in system cycles and must be at least 2. `TIMEOUT` sets the poll limit in cycles.

The state machine has these states. IDLE goes to SHIFT when a request is accepted. SHIFT sends one bit every three phases. At the end of a read header it goes to RECV, and at the end of any other frame it goes to DESEL. RECV clocks in one bit every two phases and goes to DESEL after the 16th bit. DESEL holds chip select low for one phase. From DESEL the machine goes to SHIFT with the next frame of a write, to POLL after the write frame, or to IDLE with done. POLL goes to DESEL when the serial input is high, or to IDLE with done and an error on timeout.

Top module: `seep_master`

## Requirements
- R1: After reset, busy, done, timeout_err, mw_cs, mw_sk and mw_do are all 0.
- R2: A request is accepted only when busy is low. A request raised while busy is high has no effect on the frames sent or on memory contents.
- R3: busy rises in the cycle after acceptance and stays high through a one-cycle done pulse, then falls. rdata holds the read word while done is high.
- R4: A read (req_op 0) sends 11 bits: 1, 1, 0, then the address MSB first. It then clocks in 16 data bits MSB first and drops chip select, so chip select is high for 65·CLK_DIV cycles.
- R5: A write (req_op 1) sends frames in this order, each ended by chip select going low for one phase:
  - the enable frame 1,0,0 followed by eight 1s (33·CLK_DIV cycles);
  - the write frame 1,0,1, address, data, all 27 bits MSB first (81·CLK_DIV cycles);
  - a ready poll with chip select high until mw_di is 1;
  - the lock frame 1 followed by ten 0s.
- R6: Each sent bit spans three phases of CLK_DIV cycles each: clock low, clock high, clock low. Each received bit spans two phases: clock high, then clock low. Every high pulse of mw_sk lasts exactly CLK_DIV cycles.
- R7: mw_sk is high only while mw_cs is high, and mw_do does not change while mw_sk is high or at either of its edges.
- R8: req_op 2 sends only the enable frame and req_op 3 sends only the lock frame, and each ends with done.
- R9: If mw_di stays low for TIMEOUT cycles of the ready poll, timeout_err is set and done pulses with mw_cs low. The lock frame is not sent.
- R10: timeout_err stays set until the next request is accepted, and is cleared at that acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 0 read, 1 write, 2 allow programming, 3 lock programming |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Word to write |
| busy | output | 1 | Operation in progress, up to and including done |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Word returned by the last read |
| timeout_err | output | 1 | Ready poll timed out |
| mw_cs | output | 1 | Chip select to the device |
| mw_sk | output | 1 | Serial clock to the device |
| mw_do | output | 1 | Serial data to the device |
| mw_di | input | 1 | Serial data and ready flag from the device |

## Verification
The hardest case to reach from the ports is a ready poll that never ends. A working device always finishes programming, so the POLL-to-IDLE timeout path is never taken in normal use. The bench device model therefore has a stuck mode that holds its ready line low after a write frame. With that mode on, the bench checks three things: the poll lasts exactly TIMEOUT cycles, the lock frame is missing, and the error flag clears on the next accepted read. A request raised mid-operation is also injected, to show that it leaves the device untouched.

// File: rtl/seep_pkg.sv
package seep_pkg;
    typedef enum logic [1:0] {
        HOP_READ  = 2'd0,
        HOP_WRITE = 2'd1,
        HOP_WREN  = 2'd2,
        HOP_WRDIS = 2'd3
    } host_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SHIFT,
        S_RECV,
        S_DESEL,
        S_POLL
    } fsm_e;

    // which frame of the operation is in flight
    typedef enum logic [2:0] {
        F_RD,
        F_WEN,
        F_WR,
        F_WAIT,
        F_WDS
    } frame_e;
endpackage

// File: rtl/seep_phase_timer.sv
module seep_phase_timer #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = !hold && (cnt == CW'(DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (hold || tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    generate
        if (DIV > 1) begin : g_gap
            // R6: phases are at least two cycles apart
            p_tick_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/seep_shifter.sv
module seep_shifter #(
    parameter int FW = 27,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [FW-1:0] load_val,
    input  logic          shift,
    input  logic          capture,
    input  logic          sdin,
    output logic          sout,
    output logic [DW-1:0] rdata
);
    logic [FW-1:0] sreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg  <= '0;
            rdata <= '0;
        end else begin
            if (load)
                sreg <= load_val;
            else if (shift)
                sreg <= {sreg[FW-2:0], 1'b0};
            if (capture)
                rdata <= {rdata[DW-2:0], sdin};
        end
    end

    assign sout = sreg[FW-1];
endmodule

// File: rtl/seep_master.sv
module seep_master #(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 16,
    parameter int CLK_DIV = 4,
    parameter int TIMEOUT = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              timeout_err,
    output logic              mw_cs,
    output logic              mw_sk,
    output logic              mw_do,
    input  logic              mw_di
);
    import seep_pkg::*;

    localparam int HDR_W   = 3 + ADDR_W;
    localparam int FRAME_W = HDR_W + DATA_W;
    localparam int CNT_W   = $clog2(FRAME_W);
    localparam int TO_W    = $clog2(TIMEOUT) + 1;

    fsm_e              state, nxt;
    frame_e            step, nstep;
    host_op_e          op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [1:0]        phase;
    logic [CNT_W-1:0]  bitcnt, lastbit;
    logic [TO_W-1:0]   tocnt;
    logic              done_q, err_q;

    logic               tick, accept, load, shift, capture, finish, tout, sout;
    logic [FRAME_W-1:0] lval;

    wire [FRAME_W-1:0] f_rd  = {3'b110, req_addr, {DATA_W{1'b0}}};
    wire [FRAME_W-1:0] f_wr  = {3'b101, addr_q, wdata_q};
    wire [FRAME_W-1:0] f_wen = {3'b100, {ADDR_W{1'b1}}, {DATA_W{1'b0}}};
    wire [FRAME_W-1:0] f_wds = {3'b100, {ADDR_W{1'b0}}, {DATA_W{1'b0}}};

    assign accept = req_valid && (state == S_IDLE) && !done_q;

    seep_phase_timer #(.DIV(CLK_DIV)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  ((state == S_IDLE) || (state == S_POLL)),
        .tick  (tick)
    );

    seep_shifter #(.FW(FRAME_W), .DW(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (lval),
        .shift    (shift),
        .capture  (capture),
        .sdin     (mw_di),
        .sout     (sout),
        .rdata    (rdata)
    );

    // next-state and datapath controls
    always_comb begin
        nxt = state; nstep = step;
        load = 1'b0; lval = '0; shift = 1'b0; capture = 1'b0;
        finish = 1'b0; tout = 1'b0;
        unique case (state)
            S_IDLE: if (accept) begin
                nxt  = S_SHIFT;
                load = 1'b1;
                unique case (host_op_e'(req_op))
                    HOP_READ:  begin lval = f_rd;  nstep = F_RD;  end
                    HOP_WRITE,
                    HOP_WREN:  begin lval = f_wen; nstep = F_WEN; end
                    HOP_WRDIS: begin lval = f_wds; nstep = F_WDS; end
                endcase
            end
            S_SHIFT: if (tick && phase == 2'd2) begin
                if (bitcnt == lastbit)
                    nxt = (step == F_RD) ? S_RECV : S_DESEL;
                else
                    shift = 1'b1;
            end
            S_RECV: if (tick) begin
                if (phase == 2'd0)
                    capture = 1'b1;
                else if (bitcnt == CNT_W'(DATA_W - 1))
                    nxt = S_DESEL;
            end
            S_DESEL: if (tick) begin
                if (op_q == HOP_WRITE && step == F_WEN) begin
                    load = 1'b1; lval = f_wr; nstep = F_WR; nxt = S_SHIFT;
                end else if (op_q == HOP_WRITE && step == F_WR) begin
                    nstep = F_WAIT; nxt = S_POLL;
                end else if (step == F_WAIT) begin
                    load = 1'b1; lval = f_wds; nstep = F_WDS; nxt = S_SHIFT;
                end else begin
                    nxt = S_IDLE; finish = 1'b1;
                end
            end
            S_POLL: begin
                if (tocnt == TO_W'(TIMEOUT - 1)) begin
                    nxt = S_IDLE; finish = 1'b1; tout = 1'b1;
                end else if (mw_di) begin
                    nxt = S_DESEL;
                end
            end
            default: nxt = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            step    <= F_RD;
            op_q    <= HOP_READ;
            addr_q  <= '0;
            wdata_q <= '0;
            phase   <= '0;
            bitcnt  <= '0;
            lastbit <= '0;
            tocnt   <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state  <= nxt;
            step   <= nstep;
            done_q <= finish;
            if (accept) begin
                op_q    <= host_op_e'(req_op);
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                err_q   <= 1'b0;
            end else if (tout) begin
                err_q <= 1'b1;
            end
            tocnt <= (state == S_POLL) ? tocnt + 1'b1 : '0;
            if (load) begin
                phase   <= '0;
                bitcnt  <= '0;
                lastbit <= (nstep == F_WR) ? CNT_W'(FRAME_W - 1) : CNT_W'(HDR_W - 1);
            end else if (tick && state == S_SHIFT) begin
                if (phase == 2'd2) begin
                    phase  <= '0;
                    bitcnt <= (bitcnt == lastbit) ? '0 : bitcnt + 1'b1;
                end else begin
                    phase <= phase + 1'b1;
                end
            end else if (tick && state == S_RECV) begin
                if (phase == 2'd1) begin
                    phase  <= '0;
                    bitcnt <= bitcnt + 1'b1;
                end else begin
                    phase <= 2'd1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        mw_cs       = (state == S_SHIFT) || (state == S_RECV) || (state == S_POLL);
        mw_sk       = ((state == S_SHIFT) && (phase == 2'd1)) ||
                      ((state == S_RECV)  && (phase == 2'd0));
        mw_do       = ((state == S_SHIFT) || (state == S_RECV)) && sout;
        busy        = (state != S_IDLE) || done_q;
        done        = done_q;
        timeout_err = err_q;
    end

    p_sk_in_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mw_sk |-> mw_cs);
    p_do_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mw_sk) |-> $stable(mw_do));
    p_do_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mw_sk) |-> $stable(mw_do));
    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);
    p_timeout_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err) |-> (done && !mw_cs));
endmodule

// File: tb/tb_seep_master.sv
`timescale 1ns/1ps
module tb_seep_master;
    localparam int D    = 4;
    localparam int TOUT = 600;
    localparam int BUSY = 200;
    localparam int T_RD = 1, T_WR = 2, T_WEN = 3, T_WDS = 4, T_POLL = 5, T_BAD = 9;
    localparam int NV = 11;
    // {op, addr, wdata, expected read}
    localparam logic [41:0] VEC [NV] = '{
        {2'd1, 8'hA5, 16'h1234, 16'h0000},
        {2'd1, 8'h00, 16'hFFFF, 16'h0000},
        {2'd1, 8'hFF, 16'h0001, 16'h0000},
        {2'd0, 8'hA5, 16'h0000, 16'h1234},
        {2'd0, 8'h00, 16'h0000, 16'hFFFF},
        {2'd0, 8'hFF, 16'h0000, 16'h0001},
        {2'd0, 8'h3C, 16'h0000, 16'h00FF},
        {2'd1, 8'hA5, 16'h8000, 16'h0000},
        {2'd0, 8'hA5, 16'h0000, 16'h8000},
        {2'd1, 8'h5A, 16'h0000, 16'h0000},
        {2'd0, 8'h5A, 16'h0000, 16'h0000}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [7:0]  req_addr = 8'd0;
    logic [15:0] req_wdata = 16'd0;
    logic busy, done, timeout_err, mw_cs, mw_sk, mw_do;
    logic [15:0] rdata;
    logic mw_di;
    logic stuck = 1'b0;

    always #10 clk = ~clk;

    seep_master #(.ADDR_W(8), .DATA_W(16), .CLK_DIV(D), .TIMEOUT(TOUT)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rdata(rdata), .timeout_err(timeout_err), .mw_cs(mw_cs), .mw_sk(mw_sk),
        .mw_do(mw_do), .mw_di(mw_di)
    );

    // behavioural serial EEPROM
    logic [15:0] mem [256];
    logic [26:0] fr, nf;
    int nbits, busy_cnt, cs_cnt, hi_cnt, bad_width, bad_edge, ntags, tg, idx;
    int tags [256];
    int lens [256];
    logic rd_mode, wen, sk_q, do_q, cs_q;
    logic [7:0] rd_addr;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) begin
                mem[i] = {i[7:0], ~i[7:0]} ^ 16'h3C3C;
            end
            fr <= '0; nbits <= 0; busy_cnt <= 0; cs_cnt <= 0; hi_cnt <= 0;
            bad_width <= 0; bad_edge <= 0; ntags <= 0; rd_mode <= 1'b0;
            wen <= 1'b0; sk_q <= 1'b0; do_q <= 1'b0; cs_q <= 1'b0;
            rd_addr <= '0; mw_di <= 1'b1;
        end else begin
            sk_q <= mw_sk; do_q <= mw_do; cs_q <= mw_cs;
            if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
            if (mw_sk && !mw_cs) bad_edge <= bad_edge + 1;
            if ((mw_sk || sk_q) && (mw_do != do_q)) bad_edge <= bad_edge + 1;
            if (mw_sk) hi_cnt <= hi_cnt + 1;
            else if (sk_q) begin
                if (hi_cnt != D) bad_width <= bad_width + 1;
                hi_cnt <= 0;
            end
            if (mw_cs) cs_cnt <= cs_cnt + 1;
            if (mw_cs && mw_sk && !sk_q) begin
                nbits <= nbits + 1;
                if (rd_mode) begin
                    idx = 26 - nbits;
                    if (idx >= 0 && idx < 16) mw_di <= mem[rd_addr][idx];
                end else begin
                    nf = {fr[25:0], mw_do};
                    fr <= nf;
                    if (nbits == 10 && nf[10:8] == 3'b110) begin
                        rd_mode <= 1'b1;
                        rd_addr <= nf[7:0];
                    end
                end
            end else if (!rd_mode) begin
                mw_di <= (busy_cnt == 0) && !stuck;
            end
            if (!mw_cs && cs_q) begin
                if (rd_mode) tg = T_RD;
                else if (nbits == 27 && fr[26:24] == 3'b101) tg = T_WR;
                else if (nbits == 11 && fr[10:0] == 11'b10011111111) tg = T_WEN;
                else if (nbits == 11 && fr[10:0] == 11'b10000000000) tg = T_WDS;
                else if (nbits == 0) tg = T_POLL;
                else tg = T_BAD;
                if (tg == T_WR && wen) begin
                    mem[fr[23:16]] <= fr[15:0];
                    busy_cnt <= BUSY;
                end
                if (tg == T_WEN) wen <= 1'b1;
                if (tg == T_WDS) wen <= 1'b0;
                tags[ntags] <= tg;
                lens[ntags] <= cs_cnt;
                ntags <= ntags + 1;
                cs_cnt <= 0; nbits <= 0; rd_mode <= 1'b0; fr <= '0;
            end
        end
    end

    int errors = 0, checks = 0;

    task automatic chk(input logic ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic int exp_len(input int t);
        case (t)
            T_RD:          return 65 * D;
            T_WR:          return 81 * D;
            T_WEN, T_WDS:  return 33 * D;
            default:       return -1;
        endcase
    endfunction

    task automatic check_tags(input int base, input int n, input string rq,
                              input int e0, input int e1, input int e2, input int e3);
        int e [4];
        e = '{e0, e1, e2, e3};
        chk(ntags - base == n, {rq, " frame count"}, ntags - base, n);
        for (int i = 0; i < n && i < 4; i++) begin
            chk(tags[base + i] == e[i], {rq, " frame kind"}, tags[base + i], e[i]);
            if (exp_len(e[i]) > 0)
                chk(lens[base + i] == exp_len(e[i]), "R6 chip-select length",
                    lens[base + i], exp_len(e[i]));
        end
    endtask

    task automatic run_op(input logic [1:0] op, input logic [7:0] a, input logic [15:0] wd,
                          input logic inject, output int base, output logic [15:0] rd);
        int n;
        @(negedge clk);
        base = ntags;
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R3 busy after accept", busy, 1);
        if (inject) begin
            req_valid = 1'b1; req_op = 2'd1; req_addr = a; req_wdata = 16'hDEAD;
            @(negedge clk);
            req_valid = 1'b0;
        end
        n = 0;
        while (!done && n < 4000) begin
            @(negedge clk);
            n++;
        end
        chk(done == 1'b1, "R3 done reached", done, 1);
        chk(busy == 1'b1, "R3 busy during done", busy, 1);
        rd = rdata;
        @(negedge clk);
        chk(!done && !busy, "R3 done one cycle", {done, busy}, 0);
    endtask

    task automatic tests;
        int base;
        logic [15:0] rd;
        repeat (3) @(negedge clk);
        chk({busy, done, timeout_err, mw_cs, mw_sk, mw_do} == 6'b0, "R1 reset outputs",
            {busy, done, timeout_err, mw_cs, mw_sk, mw_do}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({busy, mw_cs, mw_sk} == 3'b0, "R1 idle after reset", {busy, mw_cs, mw_sk}, 0);

        for (int v = 0; v < NV; v++) begin
            run_op(VEC[v][41:40], VEC[v][39:32], VEC[v][31:16], 1'b0, base, rd);
            if (VEC[v][41:40] == 2'd0) begin
                check_tags(base, 1, "R4", T_RD, 0, 0, 0);
                chk(rd == VEC[v][15:0], "R4 read data", rd, VEC[v][15:0]);
            end else begin
                check_tags(base, 4, "R5", T_WEN, T_WR, T_POLL, T_WDS);
                chk(mem[VEC[v][39:32]] == VEC[v][31:16], "R5 stored word",
                    mem[VEC[v][39:32]], VEC[v][31:16]);
                chk(wen == 1'b0, "R5 programming locked after write", wen, 0);
            end
        end

        // R2: request during an operation is ignored
        run_op(2'd0, 8'h11, 16'h0, 1'b1, base, rd);
        check_tags(base, 1, "R2", T_RD, 0, 0, 0);
        chk(rd == 16'h2DD2, "R2 first read", rd, 16'h2DD2);
        run_op(2'd0, 8'h11, 16'h0, 1'b0, base, rd);
        chk(rd == 16'h2DD2, "R2 word untouched", rd, 16'h2DD2);

        // R8: standalone enable / lock
        run_op(2'd2, 8'h00, 16'h0, 1'b0, base, rd);
        check_tags(base, 1, "R8 enable", T_WEN, 0, 0, 0);
        chk(wen == 1'b1, "R8 enable latched", wen, 1);
        run_op(2'd3, 8'h00, 16'h0, 1'b0, base, rd);
        check_tags(base, 1, "R8 lock", T_WDS, 0, 0, 0);
        chk(wen == 1'b0, "R8 lock latched", wen, 0);

        // R9: ready never comes
        stuck = 1'b1;
        run_op(2'd1, 8'h77, 16'h4321, 1'b0, base, rd);
        chk(timeout_err == 1'b1, "R9 error flag", timeout_err, 1);
        chk(mw_cs == 1'b0, "R9 chip select low", mw_cs, 0);
        check_tags(base, 3, "R9", T_WEN, T_WR, T_POLL, 0);
        chk(lens[base + 2] == TOUT, "R9 poll length", lens[base + 2], TOUT);
        stuck = 1'b0;
        repeat (4) @(negedge clk);
        chk(timeout_err == 1'b1, "R10 error held", timeout_err, 1);

        // R10: cleared on next accepted request
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd0; req_addr = 8'h77;
        @(negedge clk);
        req_valid = 1'b0;
        chk(timeout_err == 1'b0, "R10 error cleared", timeout_err, 0);
        while (!done) @(negedge clk);
        chk(rdata == 16'h4321, "R10 read after timeout", rdata, 16'h4321);
        repeat (3) @(negedge clk);

        chk(bad_width == 0, "R6 clock high width", bad_width, 0);
        chk(bad_edge == 0, "R7 data stable at clock", bad_edge, 0);
    endtask

    initial begin
        logic timed_out;
        timed_out = 1'b0;
        fork
            tests();
            begin
                repeat (150000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=expired expected=finished");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule